// File: doc/BRIEF.md
# Software-Loaded TLB Address Translator

This block turns a 32-bit virtual address into a physical address through a small, fully associative table of translation entries. Software fills the table one entry at a time: it writes a tag word and a data word into staging registers, points an entry selector at the slot to fill, and then issues a load command that copies both words into that slot. Every entry has its own page size (4 KB, 64 KB, 1 MB or 16 MB). The size sets how many address bits are compared and where the physical page bits are joined to the untouched offset bits.

A lookup port accepts one address per cycle and returns the result one cycle later: the physical address, the page attributes (endianness, element size, and a flag that selects the CPU element size), and either a hit or a fault. While translation is off, addresses pass through unchanged. A miss with translation on raises a fault and stores the address in a sticky fault register. Software can flush every entry that is not marked preserved. A soft reset sweeps the whole table clear, preserved entries included, and a status bit reports when the sweep has finished.

Top module: `tlbx_mmu`

## Requirements
- R1: After the reset input, register word 1 (status) reads 1 in bit 0, and register word 2 (control) and word 3 (fault address) read 0.
- R2: When control bit 1 is 0, a lookup returns the virtual address unchanged as the physical address, with hit 0, fault 0 and all attribute outputs 0.
- R3: Tag bits 1:0 give the page size: code 0 is 1 MB, 1 is 64 KB, 2 is 4 KB, 3 is 16 MB. An entry matches when the virtual address bits above the page boundary equal tag bits 31:12 over the same span. The physical address is data bits 31:12 above the boundary, joined to the virtual bits below it.
- R4: Writing word 4 (tag), word 5 (data) and word 6 (selector, with the entry index in bits 8:4), and then writing 1 to word 7 (load), stores the tag and data in that entry. Words 4 to 6 read back what was written, with word 6 returning only bits 8:4.
- R5: On a hit, the attribute outputs reflect the entry's data bit 9 (big endian), bits 8:7 (element size: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is no translation) and bit 6 (use CPU element size).
- R6: With translation on, a lookup that matches no valid entry returns fault 1, hit 0 and physical address 0. If no fault is already held, it also stores the virtual address in word 3.
- R7: A held fault address is not overwritten by later misses. Any write to word 3 clears it to 0.
- R8: An entry whose tag bit 2 (valid) is 0 never matches.
- R9: Writing 1 to word 8 (flush) invalidates every entry whose tag bit 3 (preserved) is 0 and leaves preserved entries usable.
- R10: Writing a value with bit 1 set to word 0 starts a soft reset. It clears control and the fault address at once, and the status bit reads 0 until every entry, preserved or not, has been invalidated.
- R11: When several valid entries match, the lowest-numbered entry supplies the result.
- R12: Each lookup result appears exactly one cycle after the address is presented, marked by the output valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| xl_valid_i | input | 1 | Lookup request valid |
| xl_va_i | input | 32 | Virtual address to translate |
| xl_valid_o | output | 1 | Lookup result valid |
| xl_pa_o | output | 32 | Physical address |
| xl_hit_o | output | 1 | Lookup hit a valid entry |
| xl_fault_o | output | 1 | Lookup missed with translation on |
| xl_big_end_o | output | 1 | Page is big endian |
| xl_esize_o | output | 2 | Page element size code |
| xl_cpu_esize_o | output | 1 | CPU element size takes precedence |

## Verification
A corrupted entry (wrong size code, lost valid bit, or a preserved flag ignored) shows on the very next lookup to that page. It appears as a wrong physical splice, a missing attribute bit, or a fault where a hit was due. A broken priority chooser shows as the higher-numbered entry's page on an overlapping address one cycle after the request. A fault register that updates when it should hold, or a sweep that ends early or skips entries, is visible through a register read a few cycles later and through a fault on the first lookup after re-enabling translation.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W = 32;
    localparam int PG_W = 20;

    localparam logic [3:0] RA_SYS   = 4'h0;
    localparam logic [3:0] RA_STAT  = 4'h1;
    localparam logic [3:0] RA_CTRL  = 4'h2;
    localparam logic [3:0] RA_FAULT = 4'h3;
    localparam logic [3:0] RA_TAG   = 4'h4;
    localparam logic [3:0] RA_DATA  = 4'h5;
    localparam logic [3:0] RA_LOCK  = 4'h6;
    localparam logic [3:0] RA_LOAD  = 4'h7;
    localparam logic [3:0] RA_FLUSH = 4'h8;

    typedef enum logic [1:0] {
        PS_1M  = 2'd0,
        PS_64K = 2'd1,
        PS_4K  = 2'd2,
        PS_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic       big_end;
        logic [1:0] esize;
        logic       cpu_esize;
    } pg_attr_t;

    typedef struct packed {
        logic [PG_W-1:0] vtag;
        pg_size_e        psize;
        logic            valid;
        logic            keep;
        logic [PG_W-1:0] ppage;
        pg_attr_t        attr;
    } tlb_ent_t;

    // Bits of the address that belong to the page number for a size code.
    function automatic logic [VA_W-1:0] page_mask(input pg_size_e s);
        case (s)
            PS_4K:   page_mask = 32'hFFFF_F000;
            PS_64K:  page_mask = 32'hFFFF_0000;
            PS_1M:   page_mask = 32'hFFF0_0000;
            default: page_mask = 32'hFF00_0000;
        endcase
    endfunction

    function automatic tlb_ent_t build_entry(input logic [31:0] tag_w,
                                             input logic [31:0] data_w);
        tlb_ent_t e;
        e.vtag           = tag_w[31:12];
        e.psize          = pg_size_e'(tag_w[1:0]);
        e.valid          = tag_w[2];
        e.keep           = tag_w[3];
        e.ppage          = data_w[31:12];
        e.attr.big_end   = data_w[9];
        e.attr.esize     = data_w[8:7];
        e.attr.cpu_esize = data_w[6];
        return e;
    endfunction

    function automatic logic ent_match(input tlb_ent_t e, input logic [VA_W-1:0] va);
        return e.valid && ((({e.vtag, 12'h000}) ^ va) & page_mask(e.psize)) == '0;
    endfunction

    function automatic logic [VA_W-1:0] splice(input tlb_ent_t e, input logic [VA_W-1:0] va);
        logic [VA_W-1:0] m;
        m = page_mask(e.psize);
        return ({e.ppage, 12'h000} & m) | (va & ~m);
    endfunction

endpackage

// File: rtl/tlbx_ent_store.sv
module tlbx_ent_store
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  tlb_ent_t         ld_ent,
    input  logic             flush_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [VA_W-1:0]  va,
    output tlb_ent_t         ents_o [N_ENT],
    output logic [N_ENT-1:0] match_o
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        tlb_ent_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                ent_q <= '0;
            end else if (flush_en && !ent_q.keep) begin
                ent_q.valid <= 1'b0;
            end else if (ld_en && ld_idx == IDX_W'(i)) begin
                ent_q <= ld_ent;
            end
        end

        assign ents_o[i]  = ent_q;
        assign match_o[i] = ent_match(ent_q, va);

        assert_load_commit_R4: assert property (@(posedge clk) disable iff (rst)
            (ld_en && ld_idx == IDX_W'(i) && !clr_en && !flush_en) |=> ent_q == $past(ld_ent));

        assert_flush_keep_R9: assert property (@(posedge clk) disable iff (rst)
            (flush_en && !clr_en && ent_q.keep) |=> $stable(ent_q));

        assert_sweep_clear_R10: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_idx == IDX_W'(i)) |=> !ent_q.valid);
    end

endmodule

// File: rtl/tlbx_first_hit.sv
module tlbx_first_hit #(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] match_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |match_i;

    // The chosen slot really matches and nothing below it does.
    assert_lowest_wins_R11: assert property (@(posedge clk) disable iff (rst)
        any_o |-> (match_i[idx_o] &&
                   ((match_i & ((N_ENT'(1) << idx_o) - N_ENT'(1))) == '0)));

endmodule

// File: rtl/tlbx_regs.sv
module tlbx_regs
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             miss_ev,
    input  logic [VA_W-1:0]  miss_va,
    output logic             xl_en,
    output logic             ld_en,
    output logic [IDX_W-1:0] ld_idx,
    output tlb_ent_t         ld_ent,
    output logic             flush_en,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    localparam int LOCK_LSB = 4;
    localparam int PAD_W    = 32 - LOCK_LSB - IDX_W;

    logic [31:0]     tag_q, data_q;
    logic [IDX_W-1:0] lock_q;
    logic            en_q;
    logic            flt_pend_q;
    logic [VA_W-1:0] flt_addr_q;
    logic            sweep_q;
    logic [IDX_W-1:0] sweep_idx_q;
    logic            sr_start, flt_clr;

    assign sr_start = wr_en && addr == RA_SYS && wdata[1];
    assign flt_clr  = wr_en && addr == RA_FAULT;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q       <= '0;
            data_q      <= '0;
            lock_q      <= '0;
            en_q        <= 1'b0;
            flt_pend_q  <= 1'b0;
            flt_addr_q  <= '0;
            sweep_q     <= 1'b0;
            sweep_idx_q <= '0;
        end else if (sr_start) begin
            sweep_q     <= 1'b1;
            sweep_idx_q <= '0;
            en_q        <= 1'b0;
            flt_pend_q  <= 1'b0;
            flt_addr_q  <= '0;
        end else begin
            if (sweep_q) begin
                if (sweep_idx_q == IDX_W'(N_ENT - 1)) sweep_q <= 1'b0;
                sweep_idx_q <= sweep_idx_q + IDX_W'(1);
            end
            if (wr_en) begin
                case (addr)
                    RA_CTRL: en_q   <= wdata[1];
                    RA_TAG:  tag_q  <= wdata;
                    RA_DATA: data_q <= wdata;
                    RA_LOCK: lock_q <= wdata[LOCK_LSB +: IDX_W];
                    default: ;
                endcase
            end
            if (flt_clr) begin
                flt_pend_q <= 1'b0;
                flt_addr_q <= '0;
            end else if (miss_ev && !flt_pend_q) begin
                flt_pend_q <= 1'b1;
                flt_addr_q <= miss_va;
            end
        end
    end

    assign xl_en    = en_q;
    assign ld_en    = wr_en && addr == RA_LOAD && wdata[0] && !sweep_q;
    assign ld_idx   = lock_q;
    assign ld_ent   = build_entry(tag_q, data_q);
    assign flush_en = wr_en && addr == RA_FLUSH && wdata[0] && !sweep_q;
    assign clr_en   = sweep_q;
    assign clr_idx  = sweep_idx_q;

    always_comb begin
        case (addr)
            RA_STAT:  rdata = {31'b0, !sweep_q};
            RA_CTRL:  rdata = {30'b0, en_q, 1'b0};
            RA_FAULT: rdata = flt_addr_q;
            RA_TAG:   rdata = tag_q;
            RA_DATA:  rdata = data_q;
            RA_LOCK:  rdata = {{PAD_W{1'b0}}, lock_q, {LOCK_LSB{1'b0}}};
            default:  rdata = '0;
        endcase
    end

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (flt_pend_q && !flt_clr && !sr_start) |=> (flt_pend_q && $stable(flt_addr_q)));

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
        sr_start |=> (sweep_q && !en_q && !flt_pend_q && flt_addr_q == '0));

    assert_fault_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (miss_ev && !flt_pend_q && !flt_clr && !sr_start) |=> (flt_addr_q == $past(miss_va)));

endmodule

// File: rtl/tlbx_mmu.sv
module tlbx_mmu
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        xl_valid_i,
    input  logic [31:0] xl_va_i,
    output logic        xl_valid_o,
    output logic [31:0] xl_pa_o,
    output logic        xl_hit_o,
    output logic        xl_fault_o,
    output logic        xl_big_end_o,
    output logic [1:0]  xl_esize_o,
    output logic        xl_cpu_esize_o
);

    localparam int IDX_W = $clog2(N_ENT);

    logic             xl_en, ld_en, flush_en, clr_en, any_hit, miss_ev;
    logic [IDX_W-1:0] ld_idx, clr_idx, hit_idx;
    tlb_ent_t         ld_ent;
    tlb_ent_t         ents_w [N_ENT];
    logic [N_ENT-1:0] match_w;

    logic [31:0]      pa_n;
    logic             hit_n, flt_n;
    pg_attr_t         attr_n, attr_q;

    tlbx_regs #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .miss_ev(miss_ev), .miss_va(xl_va_i),
        .xl_en(xl_en), .ld_en(ld_en), .ld_idx(ld_idx), .ld_ent(ld_ent),
        .flush_en(flush_en), .clr_en(clr_en), .clr_idx(clr_idx)
    );

    tlbx_ent_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_ent(ld_ent),
        .flush_en(flush_en), .clr_en(clr_en), .clr_idx(clr_idx),
        .va(xl_va_i), .ents_o(ents_w), .match_o(match_w)
    );

    tlbx_first_hit #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst(rst), .match_i(match_w), .any_o(any_hit), .idx_o(hit_idx)
    );

    assign miss_ev = xl_valid_i && xl_en && !any_hit;

    always_comb begin
        pa_n   = xl_va_i;
        hit_n  = 1'b0;
        flt_n  = 1'b0;
        attr_n = '0;
        if (xl_en) begin
            if (any_hit) begin
                pa_n   = splice(ents_w[hit_idx], xl_va_i);
                hit_n  = 1'b1;
                attr_n = ents_w[hit_idx].attr;
            end else begin
                pa_n   = '0;
                flt_n  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_valid_o <= 1'b0;
            xl_pa_o    <= '0;
            xl_hit_o   <= 1'b0;
            xl_fault_o <= 1'b0;
            attr_q     <= '0;
        end else begin
            xl_valid_o <= xl_valid_i;
            xl_pa_o    <= pa_n;
            xl_hit_o   <= xl_valid_i && hit_n;
            xl_fault_o <= xl_valid_i && flt_n;
            attr_q     <= attr_n;
        end
    end

    assign xl_big_end_o   = attr_q.big_end;
    assign xl_esize_o     = attr_q.esize;
    assign xl_cpu_esize_o = attr_q.cpu_esize;

    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        (xl_valid_i && !xl_en) |=> (xl_pa_o == $past(xl_va_i) && !xl_hit_o && !xl_fault_o));

    assert_fault_shape_R6: assert property (@(posedge clk) disable iff (rst)
        xl_fault_o |-> (xl_valid_o && !xl_hit_o && xl_pa_o == '0));

    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        xl_valid_i |=> xl_valid_o);

endmodule

// File: tb/sim_tlbx_mmu.sv
module sim_tlbx_mmu;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        xl_valid_i;
    logic [31:0] xl_va_i;
    logic        xl_valid_o;
    logic [31:0] xl_pa_o;
    logic        xl_hit_o, xl_fault_o, xl_big_end_o, xl_cpu_esize_o;
    logic [1:0]  xl_esize_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] pa;
        logic        hit;
        logic        flt;
        logic [3:0]  attr;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    tlbx_mmu u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xl_valid_i(xl_valid_i), .xl_va_i(xl_va_i),
        .xl_valid_o(xl_valid_o), .xl_pa_o(xl_pa_o), .xl_hit_o(xl_hit_o),
        .xl_fault_o(xl_fault_o), .xl_big_end_o(xl_big_end_o),
        .xl_esize_o(xl_esize_o), .xl_cpu_esize_o(xl_cpu_esize_o)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %0h actual %h expected %h", req, a, cfg_rdata, exp);
        end
    endtask

    task automatic load_ent(input int idx, input logic [31:0] tag, input logic [31:0] data);
        wr(4'h4, tag);
        wr(4'h5, data);
        wr(4'h6, 32'(idx) << 4);
        wr(4'h7, 32'h1);
    endtask

    // Driver: present one address for one cycle and queue its expected result.
    task automatic lookup(input logic [31:0] va, input logic [31:0] pa, input logic hit,
                          input logic flt, input logic [3:0] attr, input string req);
        exp_t e;
        @(negedge clk);
        xl_valid_i = 1'b1; xl_va_i = va;
        e.pa = pa; e.hit = hit; e.flt = flt; e.attr = attr; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        xl_valid_i = 1'b0;
    endtask

    // Monitor: compare each result as the design produces it.
    always @(negedge clk) begin
        if (!rst && xl_valid_o) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected result actual pa %h expected none", xl_pa_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (xl_pa_o !== e.pa || xl_hit_o !== e.hit || xl_fault_o !== e.flt ||
                    {xl_big_end_o, xl_esize_o, xl_cpu_esize_o} !== e.attr) begin
                    errors++;
                    $display("FAIL %s: actual pa %h hit %b flt %b attr %h expected pa %h hit %b flt %b attr %h",
                             e.req, xl_pa_o, xl_hit_o, xl_fault_o,
                             {xl_big_end_o, xl_esize_o, xl_cpu_esize_o},
                             e.pa, e.hit, e.flt, e.attr);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        xl_valid_i = 1'b0; xl_va_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(4'h1, 32'h1, "R1 status");
        rd_chk(4'h2, 32'h0, "R1 control");
        rd_chk(4'h3, 32'h0, "R1 fault");
        // R2 pass-through while disabled
        lookup(32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 4'h0, "R2 passthru");

        // Table contents (size code tag[1:0], valid tag[2], keep tag[3])
        load_ent(0,  32'h0040_1006, 32'h8000_2340); // 4K, big, esize 2, cpu
        load_ent(1,  32'h1000_0005, 32'h9000_0080); // 64K, esize 1
        load_ent(2,  32'h2000_000C, 32'hA000_0000); // 1M, preserved
        load_ent(3,  32'h3300_0007, 32'hC100_0180); // 16M, esize 3
        load_ent(4,  32'h3340_0004, 32'hD000_0000); // 1M, overlaps entry 3
        load_ent(5,  32'h5000_0002, 32'h6000_0000); // not valid
        load_ent(9,  32'h7000_0006, 32'h7100_0000);
        load_ent(10, 32'h7000_0006, 32'h7200_0000);
        rd_chk(4'h4, 32'h7000_0006, "R4 tag readback");
        rd_chk(4'h6, 32'h0000_00A0, "R4 selector readback");
        wr(4'h2, 32'h2);
        rd_chk(4'h2, 32'h2, "R2 control enable");

        lookup(32'h0040_1ABC, 32'h8000_2ABC, 1'b1, 1'b0, 4'hD, "R3 R5 4K page");
        lookup(32'h1000_BEEF, 32'h9000_BEEF, 1'b1, 1'b0, 4'h2, "R3 R5 64K page");
        lookup(32'h200A_BCDE, 32'hA00A_BCDE, 1'b1, 1'b0, 4'h0, "R3 1M page");
        lookup(32'h33AB_CDEF, 32'hC1AB_CDEF, 1'b1, 1'b0, 4'h6, "R3 R5 16M page");
        lookup(32'h3340_0123, 32'hC140_0123, 1'b1, 1'b0, 4'h6, "R11 overlap 3 vs 4");
        lookup(32'h7000_0ABC, 32'h7100_0ABC, 1'b1, 1'b0, 4'h0, "R11 duplicate 9 vs 10");

        // R8 invalid entry misses, R6 first fault captured
        lookup(32'h5000_0010, 32'h0, 1'b0, 1'b1, 4'h0, "R8 R6 invalid entry");
        rd_chk(4'h3, 32'h5000_0010, "R6 fault capture");
        // R7 second miss (outside 64K page) does not overwrite
        lookup(32'h1001_BEEF, 32'h0, 1'b0, 1'b1, 4'h0, "R3 R6 64K boundary");
        rd_chk(4'h3, 32'h5000_0010, "R7 fault hold");
        wr(4'h3, 32'h0);
        rd_chk(4'h3, 32'h0, "R7 fault clear");
        lookup(32'h0040_2000, 32'h0, 1'b0, 1'b1, 4'h0, "R3 R6 4K boundary");
        rd_chk(4'h3, 32'h0040_2000, "R6 recapture");

        // R9 flush keeps only preserved entry 2
        wr(4'h8, 32'h1);
        lookup(32'h200A_BCDE, 32'hA00A_BCDE, 1'b1, 1'b0, 4'h0, "R9 preserved survives");
        lookup(32'h0040_1ABC, 32'h0, 1'b0, 1'b1, 4'h0, "R9 flushed entry 0");
        lookup(32'h7000_0ABC, 32'h0, 1'b0, 1'b1, 4'h0, "R9 flushed entry 9");
        rd_chk(4'h3, 32'h0040_2000, "R7 hold across flush misses");

        // R10 soft reset
        wr(4'h0, 32'h2);
        rd_chk(4'h1, 32'h0, "R10 status busy");
        rd_chk(4'h2, 32'h0, "R10 control cleared");
        rd_chk(4'h3, 32'h0, "R10 fault cleared");
        repeat (40) @(negedge clk);
        rd_chk(4'h1, 32'h1, "R10 status done");
        lookup(32'h200A_BCDE, 32'h200A_BCDE, 1'b0, 1'b0, 4'h0, "R10 R2 disabled after reset");
        wr(4'h2, 32'h2);
        lookup(32'h200A_BCDE, 32'h0, 1'b0, 1'b1, 4'h0, "R10 preserved entry cleared");

        repeat (4) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R12: actual %0d pending results expected 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule